// File: doc/BRIEF.md
# MI Coherence Cache Controller

This block keeps a small private cache coherent under a protocol with only two stable line states, modified and invalid. Every miss, whether it comes from a load, an instruction fetch, a store or an atomic operation, asks the home directory for the line exclusively. The block answers exclusive requests forwarded by the directory by sending its copy of the line to the requester. When a conflict miss needs the set, it writes dirty victims back with a put request that carries the data.

Four kinds of transient state cover the gaps between request and reply: a read miss that waits for data, a write miss that waits for data, an evicted line whose put is outstanding, and an evicted line that was taken away by a forwarded request while its put was outstanding. A small associative transaction buffer holds the transient state and, for writebacks, a copy of the data, so a forwarded request can still be answered after the way has been freed. The cache is direct-mapped: the set index is the low `SET_BITS` address bits and the tag is the remaining upper bits.

There are three input channels, each valid/ready: processor requests, forwarded directory messages and data responses. There are two output message streams: requests to the directory and data responses to other caches. Each output stream is a one-cycle valid pulse. One message is consumed per cycle. Its effects appear on the registered outputs in the next cycle.

Top module: `mi_coh_ctrl`

## Requirements
- R1: While reset is held and directly after its release, `req_out_valid`, `rsp_out_valid`, `cpu_done_valid` and `proto_err` are 0.
- R2: A processor request whose line is invalid and whose set is free or holds that same address is consumed. In the next cycle one request goes out with `req_out_type`=0 (exclusive get), the request address and `req_out_data`=0. `cpu_req_type` is encoded 0 load, 1 instruction fetch, 2 store, 3 atomic. No completion is given yet.
- R3: A data response (`rsp_in_type`=0) for a line waiting on a miss is consumed and fills the line with `rsp_in_data`. In the next cycle `cpu_done_valid` is 1 with that address and data, and `cpu_done_store` is 1 when the miss came from a store or atomic request and 0 for a load or fetch.
- R4: A processor request that hits a modified line is consumed. In the next cycle it completes with the line data and sends no request message.
- R5: Processor requests to an address in any transient state are not consumed and send nothing. A forwarded exclusive request to a line waiting on a miss is not consumed.
- R6: A forwarded exclusive request (`fwd_in_type`=0) to a modified line is consumed. In the next cycle `rsp_out_valid` carries the line data, the address and `rsp_out_dest` equal to `fwd_in_requester`. The line then holds invalid, so a later processor request to it sends a new exclusive get without a replacement.
- R7: A miss whose set holds a different modified line sends a put (`req_out_type`=1) with the victim address and data, frees the set and leaves the processor request unconsumed. The request proceeds in the following cycle.
- R8: A miss whose set holds a different invalid line frees the set for one cycle, sends nothing and leaves the processor request unconsumed.
- R9: A writeback acknowledge (`fwd_in_type`=1) for an evicted line with a put outstanding is consumed, releases its transaction buffer entry and returns the address to invalid.
- R10: A forwarded exclusive request to an evicted line with a put outstanding is answered with the buffered data. A following writeback negative acknowledge (`fwd_in_type`=2) then releases the entry without a protocol error.
- R11: Channel priority is fixed. A valid response blocks the forwarded channel and the processor channel. A valid forwarded message blocks the processor channel.
- R12: A message that is not expected in the current state is consumed without changing any line, and it sets `proto_err`, which stays 1 until reset.
- R13: A miss that needs a transaction buffer entry while all `NUM_TBE` entries are busy is not consumed and sends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Processor request consumed this cycle |
| cpu_req_type | input | 2 | 0 load, 1 fetch, 2 store, 3 atomic |
| cpu_req_addr | input | AW | Line address of the request |
| fwd_in_valid | input | 1 | Forwarded directory message present |
| fwd_in_ready | output | 1 | Forwarded message consumed this cycle |
| fwd_in_type | input | 2 | 0 exclusive get, 1 writeback ack, 2 writeback nack |
| fwd_in_addr | input | AW | Address of the forwarded message |
| fwd_in_requester | input | IDW | Node that wants the line |
| rsp_in_valid | input | 1 | Incoming response present |
| rsp_in_ready | output | 1 | Response consumed this cycle |
| rsp_in_type | input | 1 | 0 data, other values unexpected |
| rsp_in_addr | input | AW | Address of the response |
| rsp_in_data | input | DW | Line data carried |
| req_out_valid | output | 1 | Directory request pulse |
| req_out_type | output | 1 | 0 exclusive get, 1 put with data |
| req_out_addr | output | AW | Request address |
| req_out_data | output | DW | Line data for a put, 0 for a get |
| rsp_out_valid | output | 1 | Data response pulse |
| rsp_out_addr | output | AW | Response address |
| rsp_out_dest | output | IDW | Destination node |
| rsp_out_data | output | DW | Line data |
| cpu_done_valid | output | 1 | Processor request completes |
| cpu_done_store | output | 1 | Completion belongs to a store or atomic request |
| cpu_done_addr | output | AW | Completed address |
| cpu_done_data | output | DW | Line data at completion |
| proto_err | output | 1 | Sticky unexpected-message flag |

## Verification
Every ready output is combinational and is due in the same cycle as the valid it answers. The bench samples it one nanosecond after driving the inputs, before the next edge. Every message and completion is registered and is due in the cycle right after the accepting edge, so the bench samples those two nanoseconds after that edge. Replacements take one unaccepted cycle before the retried request is accepted, and the bench steps through these cycle by cycle, counting the stalls. The sweep runs all four request types over every set, with fill data computed from the address.

// File: rtl/mi_pkg.sv
`timescale 1ns/1ps
package mi_pkg;
  typedef enum logic [2:0] {
    ST_I  = 3'd0,
    ST_M  = 3'd1,
    ST_IS = 3'd2,
    ST_IM = 3'd3,
    ST_MI = 3'd4,
    ST_II = 3'd5
  } mi_state_e;

  localparam logic [1:0] CPU_LOAD   = 2'd0;
  localparam logic [1:0] CPU_IFETCH = 2'd1;
  localparam logic [1:0] CPU_STORE  = 2'd2;
  localparam logic [1:0] CPU_ATOMIC = 2'd3;

  localparam logic REQ_GETX = 1'b0;
  localparam logic REQ_PUTX = 1'b1;

  localparam logic [1:0] FWD_GETX   = 2'd0;
  localparam logic [1:0] FWD_WBACK  = 2'd1;
  localparam logic [1:0] FWD_WBNACK = 2'd2;

  localparam logic RSP_DATA = 1'b0;

  function automatic logic is_transient(input mi_state_e s);
    return (s == ST_IS) || (s == ST_IM) || (s == ST_MI) || (s == ST_II);
  endfunction
endpackage

// File: rtl/mi_line_store.sv
`timescale 1ns/1ps
module mi_line_store #(
  parameter int SET_BITS = 2,
  parameter int TAG_W    = 6,
  parameter int DW       = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SET_BITS-1:0] rd_idx,
  output logic                rd_valid,
  output logic [TAG_W-1:0]    rd_tag,
  output mi_pkg::mi_state_e   rd_state,
  output logic [DW-1:0]       rd_data,
  input  logic                wr_en,
  input  logic [SET_BITS-1:0] wr_idx,
  input  logic                wr_valid,
  input  logic [TAG_W-1:0]    wr_tag,
  input  mi_pkg::mi_state_e   wr_state,
  input  logic [DW-1:0]       wr_data
);
  localparam int NUM_SETS = 1 << SET_BITS;

  logic              set_v   [NUM_SETS];
  logic [TAG_W-1:0]  set_tag [NUM_SETS];
  mi_pkg::mi_state_e set_st  [NUM_SETS];
  logic [DW-1:0]     set_dat [NUM_SETS];

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
    logic hit_wr;
    assign hit_wr = wr_en && (wr_idx == SET_BITS'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        set_v[g] <= 1'b0;
      end else if (hit_wr) begin
        set_v[g] <= wr_valid;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_wr) begin
        set_tag[g] <= wr_tag;
        set_st[g]  <= wr_state;
        set_dat[g] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_valid = set_v[rd_idx];
    rd_tag   = set_tag[rd_idx];
    rd_state = set_st[rd_idx];
    rd_data  = set_dat[rd_idx];
  end
endmodule

// File: rtl/mi_txn_buf.sv
`timescale 1ns/1ps
module mi_txn_buf #(
  parameter int NUM_TBE = 2,
  parameter int AW      = 8,
  parameter int DW      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     lk_addr,
  output logic              lk_hit,
  output mi_pkg::mi_state_e lk_state,
  output logic [DW-1:0]     lk_data,
  output logic              has_free,
  input  logic              alloc_en,
  input  logic [AW-1:0]     alloc_addr,
  input  mi_pkg::mi_state_e alloc_state,
  input  logic [DW-1:0]     alloc_data,
  input  logic              upd_en,
  input  mi_pkg::mi_state_e upd_state,
  input  logic              rel_en
);
  localparam int IW = (NUM_TBE > 1) ? $clog2(NUM_TBE) : 1;

  logic              ent_v    [NUM_TBE];
  logic [AW-1:0]     ent_addr [NUM_TBE];
  mi_pkg::mi_state_e ent_st   [NUM_TBE];
  logic [DW-1:0]     ent_dat  [NUM_TBE];
  logic [IW-1:0]     free_idx;
  logic [IW-1:0]     hit_idx;

  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    lk_hit   = 1'b0;
    hit_idx  = '0;
    for (int e = NUM_TBE - 1; e >= 0; e--) begin
      if (!ent_v[e]) begin
        has_free = 1'b1;
        free_idx = IW'(e);
      end
      if (ent_v[e] && (ent_addr[e] == lk_addr)) begin
        lk_hit  = 1'b1;
        hit_idx = IW'(e);
      end
    end
    lk_state = ent_st[hit_idx];
    lk_data  = ent_dat[hit_idx];
  end

  for (genvar g = 0; g < NUM_TBE; g++) begin : g_ent
    logic take, drop, upd;
    assign take = alloc_en && (free_idx == IW'(g));
    assign drop = rel_en && lk_hit && (hit_idx == IW'(g));
    assign upd  = upd_en && lk_hit && (hit_idx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_v[g] <= 1'b0;
      end else if (take) begin
        ent_v[g] <= 1'b1;
      end else if (drop) begin
        ent_v[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (take) begin
        ent_addr[g] <= alloc_addr;
        ent_st[g]   <= alloc_state;
        ent_dat[g]  <= alloc_data;
      end else if (upd) begin
        ent_st[g]   <= upd_state;
      end
    end
  end

  // R13
  alloc_no_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> has_free);

  // R9
  rel_without_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_en || upd_en) |-> lk_hit);
endmodule

// File: rtl/mi_coh_ctrl.sv
`timescale 1ns/1ps
module mi_coh_ctrl
  import mi_pkg::*;
#(
  parameter int AW       = 8,
  parameter int SET_BITS = 2,
  parameter int DW       = 16,
  parameter int NUM_TBE  = 2,
  parameter int IDW      = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cpu_req_valid,
  output logic           cpu_req_ready,
  input  logic [1:0]     cpu_req_type,
  input  logic [AW-1:0]  cpu_req_addr,
  input  logic           fwd_in_valid,
  output logic           fwd_in_ready,
  input  logic [1:0]     fwd_in_type,
  input  logic [AW-1:0]  fwd_in_addr,
  input  logic [IDW-1:0] fwd_in_requester,
  input  logic           rsp_in_valid,
  output logic           rsp_in_ready,
  input  logic           rsp_in_type,
  input  logic [AW-1:0]  rsp_in_addr,
  input  logic [DW-1:0]  rsp_in_data,
  output logic           req_out_valid,
  output logic           req_out_type,
  output logic [AW-1:0]  req_out_addr,
  output logic [DW-1:0]  req_out_data,
  output logic           rsp_out_valid,
  output logic [AW-1:0]  rsp_out_addr,
  output logic [IDW-1:0] rsp_out_dest,
  output logic [DW-1:0]  rsp_out_data,
  output logic           cpu_done_valid,
  output logic           cpu_done_store,
  output logic [AW-1:0]  cpu_done_addr,
  output logic [DW-1:0]  cpu_done_data,
  output logic           proto_err
);
  localparam int TAG_W = AW - SET_BITS;

  // channel selection and lookup address
  logic           use_rsp, use_fwd, use_cpu;
  logic [AW-1:0]  lk_addr;

  always_comb begin
    use_rsp = rsp_in_valid;
    use_fwd = !rsp_in_valid && fwd_in_valid;
    use_cpu = !rsp_in_valid && !fwd_in_valid && cpu_req_valid;
    if (use_rsp)      lk_addr = rsp_in_addr;
    else if (use_fwd) lk_addr = fwd_in_addr;
    else              lk_addr = cpu_req_addr;
  end

  // line store
  logic            ln_valid;
  logic [TAG_W-1:0] ln_tag;
  mi_state_e       ln_state;
  logic [DW-1:0]   ln_data;
  logic            ln_we, ln_wvalid;
  logic [TAG_W-1:0] ln_wtag;
  mi_state_e       ln_wstate;
  logic [DW-1:0]   ln_wdata;

  mi_line_store #(.SET_BITS(SET_BITS), .TAG_W(TAG_W), .DW(DW)) u_lines (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_addr[SET_BITS-1:0]),
    .rd_valid(ln_valid), .rd_tag(ln_tag), .rd_state(ln_state), .rd_data(ln_data),
    .wr_en(ln_we), .wr_idx(lk_addr[SET_BITS-1:0]), .wr_valid(ln_wvalid),
    .wr_tag(ln_wtag), .wr_state(ln_wstate), .wr_data(ln_wdata)
  );

  // transaction buffer
  logic          tb_hit, tb_free;
  mi_state_e     tb_state;
  logic [DW-1:0] tb_data;
  logic          tb_alloc, tb_upd, tb_rel;
  logic [AW-1:0] tb_aaddr;
  mi_state_e     tb_astate, tb_ustate;
  logic [DW-1:0] tb_adata;

  mi_txn_buf #(.NUM_TBE(NUM_TBE), .AW(AW), .DW(DW)) u_tbe (
    .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr),
    .lk_hit(tb_hit), .lk_state(tb_state), .lk_data(tb_data), .has_free(tb_free),
    .alloc_en(tb_alloc), .alloc_addr(tb_aaddr), .alloc_state(tb_astate),
    .alloc_data(tb_adata), .upd_en(tb_upd), .upd_state(tb_ustate), .rel_en(tb_rel)
  );

  // next-state logic
  logic          tag_hit, cpu_is_store, err_set;
  mi_state_e     cur;
  logic [AW-1:0] victim_addr;
  logic          n_req_v, n_req_t;
  logic [AW-1:0] n_req_a;
  logic [DW-1:0] n_req_d;
  logic          n_rsp_v;
  logic [AW-1:0] n_rsp_a;
  logic [IDW-1:0] n_rsp_dst;
  logic [DW-1:0] n_rsp_d;
  logic          n_done_v, n_done_st;
  logic [AW-1:0] n_done_a;
  logic [DW-1:0] n_done_d;

  always_comb begin
    tag_hit      = ln_valid && (ln_tag == lk_addr[AW-1:SET_BITS]);
    cur          = tb_hit ? tb_state : (tag_hit ? ln_state : ST_I);
    victim_addr  = {ln_tag, lk_addr[SET_BITS-1:0]};
    cpu_is_store = (cpu_req_type == CPU_STORE) || (cpu_req_type == CPU_ATOMIC);

    cpu_req_ready = 1'b0;
    fwd_in_ready  = 1'b0;
    rsp_in_ready  = 1'b0;
    err_set       = 1'b0;
    ln_we     = 1'b0;
    ln_wvalid = ln_valid;
    ln_wtag   = ln_tag;
    ln_wstate = ln_state;
    ln_wdata  = ln_data;
    tb_alloc  = 1'b0;
    tb_aaddr  = lk_addr;
    tb_astate = ST_I;
    tb_adata  = '0;
    tb_upd    = 1'b0;
    tb_ustate = ST_I;
    tb_rel    = 1'b0;
    n_req_v   = 1'b0;
    n_req_t   = REQ_GETX;
    n_req_a   = lk_addr;
    n_req_d   = '0;
    n_rsp_v   = 1'b0;
    n_rsp_a   = lk_addr;
    n_rsp_dst = fwd_in_requester;
    n_rsp_d   = ln_data;
    n_done_v  = 1'b0;
    n_done_st = 1'b0;
    n_done_a  = lk_addr;
    n_done_d  = ln_data;

    if (use_rsp) begin
      rsp_in_ready = 1'b1;
      if ((rsp_in_type == RSP_DATA) && tag_hit && ((cur == ST_IS) || (cur == ST_IM))) begin
        ln_we     = 1'b1;
        ln_wstate = ST_M;
        ln_wdata  = rsp_in_data;
        tb_rel    = 1'b1;
        n_done_v  = 1'b1;
        n_done_st = (cur == ST_IM);
        n_done_d  = rsp_in_data;
      end else begin
        err_set = 1'b1;
      end
    end else if (use_fwd) begin
      case (fwd_in_type)
        FWD_GETX: begin
          if (cur == ST_M) begin
            fwd_in_ready = 1'b1;
            ln_we        = 1'b1;
            ln_wstate    = ST_I;
            n_rsp_v      = 1'b1;
          end else if (cur == ST_MI) begin
            fwd_in_ready = 1'b1;
            tb_upd       = 1'b1;
            tb_ustate    = ST_II;
            n_rsp_v      = 1'b1;
            n_rsp_d      = tb_data;
          end else if ((cur == ST_I) || (cur == ST_II)) begin
            fwd_in_ready = 1'b1;
            err_set      = 1'b1;
          end
        end
        FWD_WBACK: begin
          fwd_in_ready = 1'b1;
          if (cur == ST_MI) tb_rel = 1'b1;
          else              err_set = 1'b1;
        end
        FWD_WBNACK: begin
          fwd_in_ready = 1'b1;
          if (cur == ST_II) tb_rel = 1'b1;
          else              err_set = 1'b1;
        end
        default: begin
          fwd_in_ready = 1'b1;
          err_set      = 1'b1;
        end
      endcase
    end else if (use_cpu) begin
      if (is_transient(cur)) begin
        cpu_req_ready = 1'b0;
      end else if (!tag_hit && ln_valid) begin
        // replacement of the resident victim; request stays queued
        if (ln_state == ST_M) begin
          if (tb_free) begin
            tb_alloc  = 1'b1;
            tb_aaddr  = victim_addr;
            tb_astate = ST_MI;
            tb_adata  = ln_data;
            n_req_v   = 1'b1;
            n_req_t   = REQ_PUTX;
            n_req_a   = victim_addr;
            n_req_d   = ln_data;
            ln_we     = 1'b1;
            ln_wvalid = 1'b0;
          end
        end else if (ln_state == ST_I) begin
          ln_we     = 1'b1;
          ln_wvalid = 1'b0;
        end
      end else if (cur == ST_I) begin
        if (tb_free) begin
          cpu_req_ready = 1'b1;
          tb_alloc  = 1'b1;
          tb_astate = cpu_is_store ? ST_IM : ST_IS;
          ln_we     = 1'b1;
          ln_wvalid = 1'b1;
          ln_wtag   = lk_addr[AW-1:SET_BITS];
          ln_wstate = cpu_is_store ? ST_IM : ST_IS;
          n_req_v   = 1'b1;
        end
      end else begin
        cpu_req_ready = 1'b1;
        n_done_v      = 1'b1;
        n_done_st     = cpu_is_store;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_out_valid  <= 1'b0;
      rsp_out_valid  <= 1'b0;
      cpu_done_valid <= 1'b0;
      proto_err      <= 1'b0;
    end else begin
      req_out_valid  <= n_req_v;
      rsp_out_valid  <= n_rsp_v;
      cpu_done_valid <= n_done_v;
      if (err_set) proto_err <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (n_req_v) begin
      req_out_type <= n_req_t;
      req_out_addr <= n_req_a;
      req_out_data <= n_req_d;
    end
    if (n_rsp_v) begin
      rsp_out_addr <= n_rsp_a;
      rsp_out_dest <= n_rsp_dst;
      rsp_out_data <= n_rsp_d;
    end
    if (n_done_v) begin
      cpu_done_store <= n_done_st;
      cpu_done_addr  <= n_done_a;
      cpu_done_data  <= n_done_d;
    end
  end

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  // R11
  rsp_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_in_valid |-> (!fwd_in_ready && !cpu_req_ready));

  // R11
  fwd_over_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_in_valid |-> !cpu_req_ready);

  // R3
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_done_valid) |-> $past((rsp_in_valid && rsp_in_ready) || (cpu_req_valid && cpu_req_ready)));

  // R6
  rsp_out_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_out_valid |-> $past(fwd_in_valid && fwd_in_ready));

  // R2
  get_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_out_valid && (req_out_type == REQ_GETX)) |-> (req_out_data == '0));
endmodule

// File: tb/tb_mi_coh_ctrl.sv
`timescale 1ns/1ps
module tb_mi_coh_ctrl;
  localparam int AW = 8, DW = 16, IDW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_req_valid, cpu_req_ready;
  logic [1:0] cpu_req_type;
  logic [AW-1:0] cpu_req_addr;
  logic fwd_in_valid, fwd_in_ready;
  logic [1:0] fwd_in_type;
  logic [AW-1:0] fwd_in_addr;
  logic [IDW-1:0] fwd_in_requester;
  logic rsp_in_valid, rsp_in_ready, rsp_in_type;
  logic [AW-1:0] rsp_in_addr;
  logic [DW-1:0] rsp_in_data;
  logic req_out_valid, req_out_type;
  logic [AW-1:0] req_out_addr;
  logic [DW-1:0] req_out_data;
  logic rsp_out_valid;
  logic [AW-1:0] rsp_out_addr;
  logic [IDW-1:0] rsp_out_dest;
  logic [DW-1:0] rsp_out_data;
  logic cpu_done_valid, cpu_done_store;
  logic [AW-1:0] cpu_done_addr;
  logic [DW-1:0] cpu_done_data;
  logic proto_err;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  mi_coh_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_type(cpu_req_type), .cpu_req_addr(cpu_req_addr),
    .fwd_in_valid(fwd_in_valid), .fwd_in_ready(fwd_in_ready),
    .fwd_in_type(fwd_in_type), .fwd_in_addr(fwd_in_addr),
    .fwd_in_requester(fwd_in_requester),
    .rsp_in_valid(rsp_in_valid), .rsp_in_ready(rsp_in_ready),
    .rsp_in_type(rsp_in_type), .rsp_in_addr(rsp_in_addr), .rsp_in_data(rsp_in_data),
    .req_out_valid(req_out_valid), .req_out_type(req_out_type),
    .req_out_addr(req_out_addr), .req_out_data(req_out_data),
    .rsp_out_valid(rsp_out_valid), .rsp_out_addr(rsp_out_addr),
    .rsp_out_dest(rsp_out_dest), .rsp_out_data(rsp_out_data),
    .cpu_done_valid(cpu_done_valid), .cpu_done_store(cpu_done_store),
    .cpu_done_addr(cpu_done_addr), .cpu_done_data(cpu_done_data),
    .proto_err(proto_err)
  );

  function automatic logic [DW-1:0] dval(input logic [AW-1:0] a);
    return {8'h00, a} * 16'd257 + 16'h1234;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic cpu_go(input logic [1:0] t, input logic [AW-1:0] a,
                        output int stalls, output int msgs);
    logic rdy;
    cpu_req_valid = 1'b1; cpu_req_type = t; cpu_req_addr = a;
    stalls = 0; msgs = 0;
    for (int k = 0; k < 8; k++) begin
      #1 rdy = cpu_req_ready;
      tick();
      if (rdy) break;
      stalls++;
      if (req_out_valid) msgs++;
    end
    cpu_req_valid = 1'b0;
  endtask

  task automatic cpu_once(input logic [1:0] t, input logic [AW-1:0] a, output logic rdy);
    cpu_req_valid = 1'b1; cpu_req_type = t; cpu_req_addr = a;
    #1 rdy = cpu_req_ready;
    tick();
    cpu_req_valid = 1'b0;
  endtask

  task automatic fwd_put(input logic [1:0] t, input logic [AW-1:0] a,
                         input logic [IDW-1:0] who, output logic rdy);
    fwd_in_valid = 1'b1; fwd_in_type = t; fwd_in_addr = a; fwd_in_requester = who;
    #1 rdy = fwd_in_ready;
    tick();
    fwd_in_valid = 1'b0;
  endtask

  task automatic rsp_put(input logic t, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, output logic rdy);
    rsp_in_valid = 1'b1; rsp_in_type = t; rsp_in_addr = a; rsp_in_data = d;
    #1 rdy = rsp_in_ready;
    tick();
    rsp_in_valid = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int st, ms;
    logic rdy;
    logic [AW-1:0] a;
    rst_n = 1'b0;
    cpu_req_valid = 0; cpu_req_type = 0; cpu_req_addr = 0;
    fwd_in_valid = 0; fwd_in_type = 0; fwd_in_addr = 0; fwd_in_requester = 0;
    rsp_in_valid = 0; rsp_in_type = 0; rsp_in_addr = 0; rsp_in_data = 0;
    repeat (3) @(posedge clk);
    #2;
    // R1
    check("R1 req_out_valid in reset", req_out_valid, 0);
    check("R1 proto_err in reset", proto_err, 0);
    rst_n = 1'b1;
    tick();
    check("R1 req_out_valid", req_out_valid, 0);
    check("R1 rsp_out_valid", rsp_out_valid, 0);
    check("R1 cpu_done_valid", cpu_done_valid, 0);
    check("R1 proto_err", proto_err, 0);

    // sweep over request types and sets
    for (int t = 0; t < 4; t++) begin
      for (int s = 0; s < 4; s++) begin
        a = AW'((t + 1) * 4 + s);
        cpu_go(2'(t), a, st, ms);
        check("R8 stall cycles", st, (t > 0) ? 1 : 0);
        check("R8 no message while freeing", ms, 0);
        check("R2 get sent", req_out_valid, 1);
        check("R2 get type", req_out_type, 0);
        check("R2 get addr", req_out_addr, a);
        check("R2 get data", req_out_data, 0);
        check("R2 no completion", cpu_done_valid, 0);
        cpu_once(2'(t), a, rdy);
        check("R5 miss pending stall", rdy, 0);
        check("R5 nothing sent", req_out_valid, 0);
        rsp_put(1'b0, a, dval(a), rdy);
        check("R3 fill taken", rdy, 1);
        check("R3 done", cpu_done_valid, 1);
        check("R3 store flag", cpu_done_store, (t >= 2) ? 1 : 0);
        check("R3 addr", cpu_done_addr, a);
        check("R3 data", cpu_done_data, dval(a));
        cpu_once(2'(t), a, rdy);
        check("R4 hit taken", rdy, 1);
        check("R4 done", cpu_done_valid, 1);
        check("R4 data", cpu_done_data, dval(a));
        check("R4 store flag", cpu_done_store, (t >= 2) ? 1 : 0);
        check("R4 no request", req_out_valid, 0);
        fwd_put(2'd0, a, IDW'(s), rdy);
        check("R6 fwd taken", rdy, 1);
        check("R6 rsp valid", rsp_out_valid, 1);
        check("R6 rsp addr", rsp_out_addr, a);
        check("R6 rsp dest", rsp_out_dest, s);
        check("R6 rsp data", rsp_out_data, dval(a));
      end
    end

    // R6: stolen line re-fetched without replacement
    cpu_go(2'd0, 8'd16, st, ms);
    check("R6 no replacement stall", st, 0);
    check("R6 refetch get", req_out_valid, 1);
    check("R6 refetch addr", req_out_addr, 16);
    rsp_put(1'b0, 8'd16, dval(8'd16), rdy);
    check("R3 refill done", cpu_done_valid, 1);

    // R7: conflict with a modified victim
    cpu_req_valid = 1; cpu_req_type = 2'd2; cpu_req_addr = 8'd20;
    #1 check("R7 not consumed", cpu_req_ready, 0);
    tick();
    check("R7 put sent", req_out_valid, 1);
    check("R7 put type", req_out_type, 1);
    check("R7 put addr", req_out_addr, 16);
    check("R7 put data", req_out_data, dval(8'd16));
    #1 check("R7 retry consumed", cpu_req_ready, 1);
    tick();
    cpu_req_valid = 0;
    check("R7 get after put", req_out_valid, 1);
    check("R7 get addr", req_out_addr, 20);

    // R13: buffer full (16 MI, 20 IM)
    cpu_req_valid = 1; cpu_req_type = 2'd0; cpu_req_addr = 8'd17;
    for (int k = 0; k < 3; k++) begin
      #1 check("R13 stalled when full", cpu_req_ready, 0);
      tick();
      check("R13 no request", req_out_valid, 0);
    end
    cpu_req_valid = 0;

    // R5: other transient states
    cpu_once(2'd0, 8'd16, rdy);
    check("R5 stall in writeback", rdy, 0);
    fwd_put(2'd0, 8'd20, 2'd1, rdy);
    check("R5 fwd stall on miss", rdy, 0);
    check("R5 no rsp while stalled", rsp_out_valid, 0);

    // R11 priority, R9 ack frees entry
    rsp_in_valid = 1; rsp_in_type = 0; rsp_in_addr = 8'd20; rsp_in_data = dval(8'd20);
    fwd_in_valid = 1; fwd_in_type = 2'd1; fwd_in_addr = 8'd16;
    cpu_req_valid = 1; cpu_req_type = 2'd0; cpu_req_addr = 8'd17;
    #1;
    check("R11 rsp ready", rsp_in_ready, 1);
    check("R11 fwd blocked", fwd_in_ready, 0);
    check("R11 cpu blocked", cpu_req_ready, 0);
    tick();
    rsp_in_valid = 0;
    check("R3 store fill done", cpu_done_valid, 1);
    check("R3 store fill flag", cpu_done_store, 1);
    check("R3 store fill data", cpu_done_data, dval(8'd20));
    #1;
    check("R11 fwd ready", fwd_in_ready, 1);
    check("R11 cpu blocked by fwd", cpu_req_ready, 0);
    tick();
    fwd_in_valid = 0;
    #1 check("R9 entry freed by ack", cpu_req_ready, 1);
    tick();
    cpu_req_valid = 0;
    check("R9 get after ack", req_out_valid, 1);
    check("R9 get addr", req_out_addr, 17);
    check("R12 ack was expected", proto_err, 0);
    rsp_put(1'b0, 8'd17, dval(8'd17), rdy);
    check("R3 load fill flag", cpu_done_store, 0);

    // R9: acked address no longer in writeback
    cpu_once(2'd0, 8'd16, rdy);
    check("R9 not stalled as writeback", req_out_valid, 1);
    check("R7 victim put", req_out_type, 1);
    check("R7 victim addr", req_out_addr, 20);
    check("R7 victim data", req_out_data, dval(8'd20));
    cpu_go(2'd1, 8'd16, st, ms);
    check("R2 fetch get", req_out_addr, 16);
    fwd_put(2'd0, 8'd16, 2'd3, rdy);
    check("R5 fwd stall on read miss", rdy, 0);

    // R10: steal during writeback
    fwd_put(2'd0, 8'd20, 2'd2, rdy);
    check("R10 fwd taken", rdy, 1);
    check("R10 rsp valid", rsp_out_valid, 1);
    check("R10 rsp data from buffer", rsp_out_data, dval(8'd20));
    check("R10 rsp dest", rsp_out_dest, 2);
    fwd_put(2'd2, 8'd20, 2'd0, rdy);
    check("R10 nack taken", rdy, 1);
    check("R10 no error", proto_err, 0);
    rsp_put(1'b0, 8'd16, dval(8'd16), rdy);
    check("R3 fetch fill", cpu_done_data, dval(8'd16));

    // R12: unexpected messages
    fwd_put(2'd1, 8'd16, 2'd0, rdy);
    check("R12 stray ack consumed", rdy, 1);
    check("R12 error raised", proto_err, 1);
    cpu_once(2'd0, 8'd16, rdy);
    check("R12 line unchanged hit", cpu_done_valid, 1);
    check("R12 line data kept", cpu_done_data, dval(8'd16));
    rsp_put(1'b1, 8'd16, 16'h0, rdy);
    check("R12 bad response consumed", rdy, 1);
    check("R12 no completion", cpu_done_valid, 0);
    tick(); tick();
    check("R12 error sticky", proto_err, 1);

    summary();
    $finish;
  end
endmodule